// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block is a single-port synchronous static memory with late-write timing. Each rising clock edge captures an address, a chip select, a global write enable and a mask of per-lane write enables. When the access is a write, its data is taken from the data bus on the next rising edge, so the data phase of one write overlaps the address phase of the following access. Read data comes from a register that is loaded on the edge that accepts the read.

A pending-write register holds the address and lane mask of a write until its data arrives. The array is written on the edge that captures that data. If a read on that same edge targets the committing address, the read register takes the newly arriving bytes for the enabled lanes and the stored bytes for the rest. An asynchronous output enable and a sleep input together control a separate drive-enable output that stands in for tri-stated data pins. Sleep blocks new accesses. It does not cancel a write whose data phase is already under way.

The word is built from 9-bit lanes. There are two lanes (18 bits) by default, and four lanes (36 bits) as an option.

Top module: `lwSram`

## Requirements
- R1: While reset is asserted, and after it until the first read, `rdData` is zero and no write is pending.
- R2: A write accepted on edge N stores the `wrData` value present at edge N+1. `wrData` at an edge that follows no accepted write changes no stored word.
- R3: A read accepted on edge N loads `rdData` with the addressed word at edge N. `rdData` keeps its value on every edge that accepts no read.
- R4: Only the lanes whose `laneEn` bit is 1 are written. Lane l occupies bits [9*l+8 : 9*l] of the word.
- R5: A read accepted on the same edge that commits a write to the same address returns, for each lane, the committing data if that lane is enabled and the stored data otherwise.
- R6: Writes on consecutive edges all complete. Each edge commits the earlier write's data and captures the next write's address.
- R7: An edge with `chipSel` low performs no access. It still commits a write accepted on the edge before it.
- R8: With `sleep` high, no read or write is accepted, stored words are kept, and `rdDrive` is low. A write accepted before sleep still commits.
- R9: `rdDrive` is high exactly when `outEn` is high and `sleep` is low. It follows both inputs without waiting for a clock edge.
- R10: The parameter `LANES` selects 2 lanes (18-bit word) or 4 lanes (36-bit word).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Blocks new accesses and disables output drive |
| chipSel | input | 1 | Selects the memory for an access on this edge |
| writeEn | input | 1 | 1 = write access, 0 = read access |
| laneEn | input | LANES | Per-lane write enables, sampled with the address |
| addr | input | ADDR_W | Word address |
| wrData | input | 9*LANES | Write data, sampled one edge after its address |
| outEn | input | 1 | Asynchronous output enable |
| rdData | output | 9*LANES | Registered read data |
| rdDrive | output | 1 | Drive enable for the data outputs |

## Verification
If the pending register were wrong, a lost, misdirected or wrongly masked write would not show at once. It would appear only on the next read of the affected address, which can come many cycles later. The bench therefore fills every address, reads each word back, and mixes reads in among random traffic. A broken per-lane bypass shows on the very edge where a read meets a committing write: the read returns a stale byte in one lane. The bench places such collisions on purpose. Faults in the drive enable show at once and need no clock, so the bench samples `rdDrive` between edges.

// File: rtl/lwSramPkg.sv
package lwSramPkg;
  localparam int LANE_W = 9;

  // strobes from control to datapath for one clock edge
  typedef struct packed {
    logic commit;   // pending write data is taken this edge
    logic read;     // a read is accepted this edge
    logic hit;      // the read targets the committing address
  } lwStrobes_t;

  function automatic logic accessOk(input logic cs, input logic sl);
    return cs && !sl;
  endfunction
endpackage

// File: rtl/lwSramCtrl.sv
module lwSramCtrl
  import lwSramPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleep,
  input  logic              chipSel,
  input  logic              writeEn,
  input  logic [LANES-1:0]  laneEn,
  input  logic [ADDR_W-1:0] addr,
  output lwStrobes_t        strobes,
  output logic [ADDR_W-1:0] commitAddr,
  output logic [LANES-1:0]  commitMask
);
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [LANES-1:0]  pendMask;
  logic              accepted;

  assign accepted = accessOk(chipSel, sleep);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendMask  <= '0;
    end else begin
      pendValid <= accepted && writeEn;
      if (accepted && writeEn) begin
        pendAddr <= addr;
        pendMask <= laneEn;
      end
    end
  end

  always_comb begin
    strobes.commit = pendValid;
    strobes.read   = accepted && !writeEn;
    strobes.hit    = pendValid && accepted && !writeEn && (pendAddr == addr);
  end

  assign commitAddr = pendAddr;
  assign commitMask = pendMask;
endmodule

// File: rtl/lwSramLane.sv
module lwSramLane
  import lwSramPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LANE_W-1:0] wrLane,
  input  logic              rdStb,
  input  logic              bypass,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [LANE_W-1:0] rdLane
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wrStb) cells[wrAddr] <= wrLane;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdLane <= '0;
    else if (rdStb) rdLane <= bypass ? wrLane : cells[rdAddr];
  end
endmodule

// File: rtl/lwSramData.sv
module lwSramData
  import lwSramPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  lwStrobes_t        strobes,
  input  logic [ADDR_W-1:0] commitAddr,
  input  logic [LANES-1:0]  commitMask,
  input  logic [ADDR_W-1:0] readAddr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lwSramLane #(.ADDR_W(ADDR_W)) u_lane (
      .clk    (clk),
      .rstN   (rstN),
      .wrStb  (strobes.commit && commitMask[l]),
      .wrAddr (commitAddr),
      .wrLane (wrData[l*LANE_W +: LANE_W]),
      .rdStb  (strobes.read),
      .bypass (strobes.hit && commitMask[l]),
      .rdAddr (readAddr),
      .rdLane (rdData[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/lwSram.sv
module lwSram
  import lwSramPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleep,
  input  logic              chipSel,
  input  logic              writeEn,
  input  logic [LANES-1:0]  laneEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              outEn,
  output logic [WORD_W-1:0] rdData,
  output logic              rdDrive
);
  // R10: only the 18-bit and 36-bit organisations are built
  if (LANES != 2 && LANES != 4) begin : g_bad_lanes
    initial $error("lwSram: LANES must be 2 or 4");
  end

  lwStrobes_t        strobes;
  logic [ADDR_W-1:0] commitAddr;
  logic [LANES-1:0]  commitMask;

  lwSramCtrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sleep(sleep), .chipSel(chipSel),
    .writeEn(writeEn), .laneEn(laneEn), .addr(addr),
    .strobes(strobes), .commitAddr(commitAddr), .commitMask(commitMask)
  );

  lwSramData #(.ADDR_W(ADDR_W), .LANES(LANES)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .commitAddr(commitAddr),
    .commitMask(commitMask), .readAddr(addr), .wrData(wrData),
    .rdData(rdData)
  );

  // R9: asynchronous drive gating
  assign rdDrive = outEn && !sleep;
endmodule

// File: rtl/lwSramChk.sv
module lwSramChk #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  localparam int WORD_W = LANES * 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              sleep,
  input logic              chipSel,
  input logic              writeEn,
  input logic              outEn,
  input logic [WORD_W-1:0] rdData,
  input logic              rdDrive,
  input logic              commitStb,
  input logic              hitStb
);
  // R2
  commit_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && !sleep && writeEn) |=> commitStb);

  // R7
  commit_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> $past(chipSel && !sleep && writeEn));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(chipSel && !sleep && !writeEn) |=> $stable(rdData));

  // R5
  hit_needs_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitStb |-> commitStb);

  // R8
  sleep_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !rdDrive);

  // R9
  always_comb begin
    if (rstN && !outEn) begin
      oe_off_chk: assert (!rdDrive);
    end
  end
endmodule

bind lwSram lwSramChk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rstN(rstN), .sleep(sleep), .chipSel(chipSel),
  .writeEn(writeEn), .outEn(outEn), .rdData(rdData), .rdDrive(rdDrive),
  .commitStb(strobes.commit), .hitStb(strobes.hit)
);

// File: tb/tb_lwSram.sv
module tb_lwSram;
  localparam int AW = 4;
  localparam int LN = 2;
  localparam int WW = LN * 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleep = 1'b0, chipSel = 1'b0, writeEn = 1'b0, outEn = 1'b1;
  logic [LN-1:0] laneEn = '0;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wrData = '0;
  logic [WW-1:0] rdData;
  logic rdDrive;

  always #4 clk = ~clk;  // 125 MHz

  lwSram #(.ADDR_W(AW), .LANES(LN)) dut (
    .clk(clk), .rstN(rstN), .sleep(sleep), .chipSel(chipSel),
    .writeEn(writeEn), .laneEn(laneEn), .addr(addr), .wrData(wrData),
    .outEn(outEn), .rdData(rdData), .rdDrive(rdDrive)
  );

  int total = 0, bad = 0;
  bit done = 0;

  logic [WW-1:0] model [DEPTH];
  logic [WW-1:0] expRd = '0;
  bit            bPend = 0;
  logic [AW-1:0] bPendAddr;
  logic [LN-1:0] bPendMask;
  logic [WW-1:0] bPendData;

  function automatic logic [WW-1:0] merge(input logic [WW-1:0] oldW,
      input logic [WW-1:0] newW, input logic [LN-1:0] m);
    logic [WW-1:0] r = oldW;
    for (int l = 0; l < LN; l++)
      if (m[l]) r[l*9 +: 9] = newW[l*9 +: 9];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag,
      input logic [WW-1:0] act, input logic [WW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit cs, input bit we, input bit sl,
      input logic [LN-1:0] m, input logic [AW-1:0] a, input string tag);
    bit acc;
    @(negedge clk);
    chipSel = cs; writeEn = we; sleep = sl; laneEn = m; addr = a;
    wrData = bPend ? bPendData : WW'($urandom);
    acc = cs && !sl;
    if (acc && !we)
      expRd = merge(model[a], wrData, (bPend && bPendAddr == a) ? bPendMask : '0);
    if (bPend) model[bPendAddr] = merge(model[bPendAddr], wrData, bPendMask);
    bPend = acc && we;
    if (bPend) begin
      bPendAddr = a; bPendMask = m; bPendData = WW'($urandom);
    end
    @(posedge clk); #2;
    check(rdData == expRd, tag, rdData, expRd);
    check(rdDrive == (outEn && !sleep), sl ? "R8" : "R9",
          WW'(rdDrive), WW'(outEn && !sleep));
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      check(1'b0, "watchdog", '0, '0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    check(rdData == '0, "R1", rdData, '0);
    check(rdDrive == 1'b1, "R9", WW'(rdDrive), WW'(1));
    rstN = 1'b1;
    // R1: garbage data with nothing pending writes nothing
    step(0, 0, 0, '0, 0, "R1");
    // R6: back-to-back full-word writes fill every address
    for (int i = 0; i < DEPTH; i++) step(1, 1, 0, '1, AW'(i), "R6");
    // R3, R2: read every word back
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, '0, AW'(i), "R3");
    // R4: lane 0 only, then lane 1 only
    step(1, 1, 0, 2'b01, 4'd5, "R4");
    step(0, 0, 0, '0, 0, "R4");
    step(1, 0, 0, '0, 4'd5, "R4");
    step(1, 1, 0, 2'b10, 4'd6, "R4");
    step(0, 0, 0, '0, 0, "R4");
    step(1, 0, 0, '0, 4'd6, "R4");
    // R5: read during commit to same address, partial mask
    step(1, 1, 0, 2'b10, 4'd7, "R5");
    step(1, 0, 0, '0, 4'd7, "R5");
    step(1, 1, 0, 2'b01, 4'd7, "R5");
    step(1, 0, 0, '0, 4'd7, "R5");
    step(1, 0, 0, '0, 4'd7, "R5");
    // R7: deselect between write and read
    step(1, 1, 0, '1, 4'd8, "R7");
    step(0, 1, 0, '1, 4'd9, "R7");
    step(1, 0, 0, '0, 4'd8, "R7");
    step(1, 0, 0, '0, 4'd9, "R7");
    // R8: write then sleep; sleeping read/write ignored; data kept
    step(1, 1, 0, '1, 4'd3, "R8");
    step(1, 0, 1, '0, 4'd3, "R8");
    step(1, 1, 1, '1, 4'd4, "R8");
    step(0, 0, 1, '0, 0, "R8");
    step(1, 0, 0, '0, 4'd3, "R8");
    step(1, 0, 0, '0, 4'd4, "R8");
    // R9: outEn acts without a clock edge
    @(negedge clk); #1;
    outEn = 1'b0; #1;
    check(rdDrive == 1'b0, "R9", WW'(rdDrive), '0);
    outEn = 1'b1; #1;
    check(rdDrive == 1'b1, "R9", WW'(rdDrive), WW'(1));
    // R10, R4, R5, R6: random traffic
    for (int i = 0; i < 3000; i++) begin
      bit cs, we, sl;
      cs = ($urandom % 8) != 0;
      we = ($urandom % 2) != 0;
      sl = ($urandom % 16) == 0;
      outEn = ($urandom % 8) != 0;
      step(cs, we, sl, LN'($urandom), AW'($urandom), "R10");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule